// File: doc/BRIEF.md
# Software-Clocked Serial EEPROM Responder

This block stands in for a small serial EEPROM behind one memory-mapped control register. Host software never touches real pins: it writes the register repeatedly, toggling a clock bit, a select bit and a data-in bit. Each time a write raises the clock bit from 0 to 1 while select is set, the block takes one serial step. The first eight steps collect an opcode, most significant bit first. A read command then takes an eight-bit byte address and returns a sixteen-bit word over sixteen further steps. A status command returns eight zero bits. The returned bit appears on a data-out bit of the same register.

The storage is 64 words of sixteen bits, loaded at reset. The first three words hold a station address, and the last word is a checksum that brings the 16-bit sum of all words to a fixed constant. Words are addressed by the byte address shifted right by one. Only the read and read-status commands are supported. Any other opcode raises an error output, which stays up until select is dropped. A request bit in the register is copied to a grant bit on every write, so access is granted at once.

Top module: `spi_eeprom_responder`

## Requirements
- R1: After reset the control register reads all zero and err_o is low.
- R2: A serial step happens only on a write whose clock bit (bit 0) is 1 while the stored clock bit is 0 and whose select bit (bit 1) is 1. Further writes that keep the clock bit at 1 take no step, whatever their data-in bit (bit 2) holds.
- R3: The first 8 steps shift data-in into the opcode, most significant bit first. The read opcode is 0x03, and it is followed by 8 steps that shift in a byte address, most significant bit first.
- R4: After a read opcode and address, each of the next 16 steps sets data-out (read bit 3) to bit 15-n of word address[6:1], where n counts 0 to 15. Address bit 7 is ignored.
- R5: The read-status opcode is 0x05. Each of the 8 steps that follow it drives data-out to 0.
- R6: After the last data bit of a read (16) or of a read-status (8), the opcode, address and counters clear. The next command may follow without dropping select.
- R7: Once 8 opcode bits hold a value other than 0x03 or 0x05, err_o goes high. Later steps change neither err_o nor data-out.
- R8: Any write with the select bit at 0 aborts a partial command, clears the counters and clears err_o.
- R9: On every write the grant bit (read bit 5) takes the value of the request bit (bit 4) of that write.
- R10: Words 0, 1 and 2 hold 0xA4A4, 0xB6B6 and 0xC8C8. Words 3 to 62 hold zero. Word 63 holds 0x9698, so the 16-bit sum of all 64 words is 0xBABA.
- R11: A register read returns stored clock at bit 0, data-out at bit 3, request at bit 4 and grant at bit 5. Every other bit, including select and data-in, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 32 | Control register write value |
| rd_data_o | output | 32 | Control register read value |
| err_o | output | 1 | Unsupported opcode seen |

## Verification
Reads are run at several addresses: even and odd byte addresses, the last word, a zero word, and an address with bit 7 set. Together they separate the word-index mapping from the bit order and show how address bits are dropped. Three stimuli probe step detection: repeated clock-high writes carrying different data-in values, a status command issued after data-out was left at 1, and back-to-back commands sent without deselecting. An unknown opcode, followed by more steps and then a deselect, shows how the error output holds and clears. Reading out all 64 words shows the checksum.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;
  typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DATA, PH_ERR} phase_e;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_RDSR = 8'h05;

  // control register bit positions
  localparam int CB_CLK  = 0;
  localparam int CB_SEL  = 1;
  localparam int CB_DIN  = 2;
  localparam int CB_DOUT = 3;
  localparam int CB_REQ  = 4;
  localparam int CB_GNT  = 5;
endpackage

// File: rtl/spi_rom_image.sv
module spi_rom_image #(
  parameter int              WORDS  = 64,
  parameter int              WORD_W = 16,
  parameter logic [15:0]     CSUM   = 16'hBABA,
  parameter logic [15:0]     W0     = 16'hA4A4,
  parameter logic [15:0]     W1     = 16'hB6B6,
  parameter logic [15:0]     W2     = 16'hC8C8,
  localparam int             IDX_W  = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [WORD_W-1:0] SEED_SUM = WORD_W'(W0) + WORD_W'(W1) + WORD_W'(W2);
  localparam logic [WORD_W-1:0] LAST_W   = WORD_W'(CSUM) - SEED_SUM;

  logic [WORD_W-1:0] mem_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [WORD_W-1:0] INIT =
      (i == 0)         ? WORD_W'(W0) :
      (i == 1)         ? WORD_W'(W1) :
      (i == 2)         ? WORD_W'(W2) :
      (i == WORDS - 1) ? LAST_W      : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= INIT;
      else         mem_q[i] <= mem_q[i];
    end
  end

  assign word_o = mem_q[idx_i];

  logic [WORD_W-1:0] mem_sum;
  always_comb begin
    mem_sum = '0;
    for (int k = 0; k < WORDS; k++) mem_sum = mem_sum + mem_q[k];
  end

  assert_image_checksum_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sum == WORD_W'(CSUM));
endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
  import spi_rom_pkg::*;
#(
  parameter int OP_W      = 8,
  parameter int ADDR_W    = 8,
  parameter int WORD_W    = 16,
  parameter int STAT_BITS = 8,
  localparam int MAXB  = (WORD_W > OP_W) ? ((WORD_W > ADDR_W) ? WORD_W : ADDR_W)
                                         : ((OP_W > ADDR_W) ? OP_W : ADDR_W),
  localparam int CNT_W = $clog2(MAXB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              abort_i,
  input  logic              din_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dout_o,
  output logic              err_o
);
  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OP_W-1:0]   op_q, op_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic              dout_q;
  logic              is_read;
  logic [CNT_W-1:0]  last_cnt, bit_sel;

  assign op_nxt   = {op_q[OP_W-2:0], din_i};
  assign is_read  = (op_q == OP_W'(OP_READ));
  assign last_cnt = is_read ? CNT_W'(WORD_W - 1) : CNT_W'(STAT_BITS - 1);
  assign bit_sel  = CNT_W'(WORD_W - 1) - cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OP;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      dout_q  <= 1'b0;
    end else if (abort_i) begin
      phase_q <= PH_OP;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
    end else if (step_i) begin
      unique case (phase_q)
        PH_OP: begin
          op_q <= op_nxt;
          if (cnt_q == CNT_W'(OP_W - 1)) begin
            cnt_q <= '0;
            if (op_nxt == OP_W'(OP_READ))      phase_q <= PH_ADDR;
            else if (op_nxt == OP_W'(OP_RDSR)) phase_q <= PH_DATA;
            else                               phase_q <= PH_ERR;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_ADDR: begin
          addr_q <= {addr_q[ADDR_W-2:0], din_i};
          if (cnt_q == CNT_W'(ADDR_W - 1)) begin
            cnt_q   <= '0;
            phase_q <= PH_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          dout_q <= is_read ? word_i[bit_sel] : 1'b0;
          if (cnt_q == last_cnt) begin
            phase_q <= PH_OP;
            cnt_q   <= '0;
            op_q    <= '0;
            addr_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ; // error phase: wait for deselect
      endcase
    end
  end

  assign addr_o = addr_q;
  assign dout_o = dout_q;
  assign err_o  = (phase_q == PH_ERR);

  assert_err_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !abort_i) |=> (err_o && $stable(dout_o)));
  assert_dout_needs_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(dout_o));
  assert_abort_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (cnt_q == '0 && phase_q == PH_OP && !err_o));
  assert_status_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !abort_i && phase_q == PH_DATA && !is_read) |=> !dout_o);
  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA) |-> (cnt_q <= last_cnt));
endmodule

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
  import spi_rom_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             dout_i,
  output logic             step_o,
  output logic             abort_o,
  output logic             din_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic clk_q, req_q, gnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= 1'b0;
      req_q <= 1'b0;
      gnt_q <= 1'b0;
    end else if (wr_en_i) begin
      clk_q <= wr_data_i[CB_CLK];
      req_q <= wr_data_i[CB_REQ];
      gnt_q <= wr_data_i[CB_REQ]; // immediate grant
    end
  end

  assign step_o  = wr_en_i && wr_data_i[CB_SEL] && wr_data_i[CB_CLK] && !clk_q;
  assign abort_o = wr_en_i && !wr_data_i[CB_SEL];
  assign din_o   = wr_data_i[CB_DIN];

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[CB_CLK]  = clk_q;
    rd_data_o[CB_DOUT] = dout_i;
    rd_data_o[CB_REQ]  = req_q;
    rd_data_o[CB_GNT]  = gnt_q;
  end

  assert_grant_tracks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (gnt_q == $past(wr_data_i[CB_REQ])));
  assert_no_step_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(clk_q));
endmodule

// File: rtl/spi_eeprom_responder.sv
module spi_eeprom_responder #(
  parameter int          REG_W  = 32,
  parameter int          WORDS  = 64,
  parameter int          WORD_W = 16,
  parameter int          OP_W   = 8,
  parameter int          ADDR_W = 8,
  parameter logic [15:0] CSUM   = 16'hBABA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             err_o
);
  localparam int IDX_W = $clog2(WORDS);

  logic              step, abort, din, dout;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] word;

  spi_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .dout_i(dout), .step_o(step), .abort_o(abort), .din_o(din), .rd_data_o
  );

  spi_shift_fsm #(.OP_W(OP_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .STAT_BITS(8)) u_fsm (
    .clk_i, .rst_ni, .step_i(step), .abort_i(abort), .din_i(din),
    .word_i(word), .addr_o(addr), .dout_o(dout), .err_o
  );

  spi_rom_image #(.WORDS(WORDS), .WORD_W(WORD_W), .CSUM(CSUM)) u_rom (
    .clk_i, .rst_ni, .idx_i(addr[IDX_W:1]), .word_o(word)
  );
endmodule

// File: tb/spi_eeprom_responder_test.sv
module spi_eeprom_responder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        err;
  int checks = 0, fails = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  spi_eeprom_responder uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .err_o(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit0 clk, bit1 sel, bit2 din, bit4 req
  task automatic wr(input bit sel, input bit ck, input bit di, input bit rq = 1'b0);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = {26'd0, 1'b0, rq, 1'b0, di, sel, ck};
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      wr(1, 0, v[i]);
      wr(1, 1, v[i]);
    end
  endtask

  task automatic read_word(input logic [7:0] a, output logic [15:0] w);
    send_bits(8'h03);
    send_bits(a);
    for (int i = 15; i >= 0; i--) begin
      wr(1, 0, 0);
      wr(1, 1, 0);
      w[i] = rd_data[3];
    end
  endtask

  task automatic t_reset;
    check("R1 reg", rd_data, 32'h0);
    check("R1 err", {31'd0, err}, 32'h0);
  endtask

  task automatic t_reads;
    logic [15:0] w;
    read_word(8'h00, w); check("R4 word0", {16'd0, w}, 32'hA4A4);
    read_word(8'h05, w); check("R4 odd addr word2", {16'd0, w}, 32'hC8C8);
    read_word(8'h7E, w); check("R10 last word", {16'd0, w}, 32'h9698);
    read_word(8'h10, w); check("R10 zero word", {16'd0, w}, 32'h0);
    read_word(8'h83, w); check("R4 bit7 ignored", {16'd0, w}, 32'hB6B6);
    wr(0, 0, 0);
  endtask

  task automatic t_edge_only;
    logic [15:0] w;
    wr(1, 0, 0); wr(1, 1, 0);
    wr(1, 1, 1); wr(1, 1, 1); // no steps R2
    for (int i = 6; i >= 0; i--) begin
      wr(1, 0, (i < 2)); wr(1, 1, (i < 2));
    end
    send_bits(8'h02);
    for (int i = 15; i >= 0; i--) begin
      wr(1, 0, 0); wr(1, 1, 0); w[i] = rd_data[3];
    end
    check("R2 held clock no shift", {16'd0, w}, 32'hB6B6);
    check("R3 opcode accepted", {31'd0, err}, 32'h0);
    wr(0, 0, 0);
  endtask

  task automatic t_status_abort;
    logic [15:0] w;
    send_bits(8'h03); send_bits(8'h00);
    wr(1, 0, 0); wr(1, 1, 0);
    check("R4 first bit", {31'd0, rd_data[3]}, 32'h1);
    wr(0, 0, 0); // abort R8
    send_bits(8'h05);
    for (int i = 0; i < 8; i++) begin
      wr(1, 0, 1); wr(1, 1, 1);
      check("R5 status bit", {31'd0, rd_data[3]}, 32'h0);
    end
    read_word(8'h02, w); // back to back R6
    check("R6 follow-on read", {16'd0, w}, 32'hB6B6);
    wr(0, 0, 0);
  endtask

  task automatic t_bad_op;
    logic [15:0] w;
    for (int i = 0; i < 7; i++) begin wr(1, 0, 1); wr(1, 1, 1); end
    check("R7 err before 8th", {31'd0, err}, 32'h0);
    wr(1, 0, 1); wr(1, 1, 1);
    check("R7 err set", {31'd0, err}, 32'h1);
    for (int i = 0; i < 4; i++) begin wr(1, 0, 1); wr(1, 1, 1); end
    check("R7 err held", {31'd0, err}, 32'h1);
    check("R7 dout held", {31'd0, rd_data[3]}, 32'h0);
    wr(0, 0, 0);
    check("R8 deselect clears err", {31'd0, err}, 32'h0);
    read_word(8'h00, w);
    check("R8 read after abort", {16'd0, w}, 32'hA4A4);
    wr(0, 0, 0);
  endtask

  task automatic t_grant_layout;
    wr(0, 0, 0, 1);
    check("R9 grant on", {26'd0, rd_data[5:4]}, 32'h3);
    wr(0, 0, 0, 0);
    check("R9 grant off", {26'd0, rd_data[5:4]}, 32'h0);
    wr(1, 0, 1, 0);
    check("R11 sel din read zero", rd_data, 32'h0);
    wr(1, 1, 0, 0);
    check("R11 clk bit", rd_data, 32'h1);
    wr(0, 0, 0);
  endtask

  task automatic t_checksum;
    logic [15:0] w, s;
    s = '0;
    for (int i = 0; i < 64; i++) begin
      read_word(8'(i * 2), w);
      s = s + w;
    end
    check("R10 checksum", {16'd0, s}, 32'hBABA);
    wr(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reads();
    t_edge_only();
    t_status_abort();
    t_bad_op();
    t_grant_layout();
    t_checksum();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule